// File: doc/BRIEF.md
# Conflict-Free Memory Bank Selector

This block sits in front of a packet buffer built from several slow, interleaved memory banks. Time is divided into slots of one fixed-size packet each, and `SLOTS_PER_FRAME` consecutive slots form a frame. Every arriving packet already carries the slot in which it must leave. The block uses that slot to pick a bank for the packet. The bank it picks is busy with no other access during the two frames that matter: the frame in which the packet is written and the frame in which it is fetched again.

The block keeps two pieces of state. A circular bitmap has one row per frame and one bit per bank. A bit set in a row means that bank owes a read during that frame. A reservation vector marks the banks that have already taken a write in the current frame. For each arrival, three masks are merged: the reservation vector, the row of the arrival frame and the row of the fetch frame. The lowest-numbered bank that is free in all three is chosen. The bank count is `3*SLOTS_PER_FRAME-1`, so a free bank always exists.

Packets that leave too soon to make the round trip through a bank are flagged for a small side buffer instead. The word address inside the chosen bank is the departure frame taken modulo the bitmap depth.

Top module: `bank_conflict_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `res_valid` and `res_bypass` are 0.
- R2: An arrival with `dep_slot < now_slot` or `dep_slot - now_slot < 4*SLOTS_PER_FRAME-1` produces `res_bypass`=1, with `res_bank`=0 and `res_addr`=0. Any other arrival produces `res_bypass`=0.
- R3: For a banked arrival, let f = floor(now_slot/SLOTS_PER_FRAME) and let d = floor(dep_slot/SLOTS_PER_FRAME)-1. `res_bank` is the lowest bank index that holds no write reservation in frame f, owes no read in frame f and owes no read in frame d.
- R4: A banked assignment to bank n reserves n for the rest of frame f and marks n as owing a read in frame d.
- R5: All write reservations are released when `now_slot` enters a new frame, and an arrival in the first slot of that frame already sees them released.
- R6: When a frame ends, its row of the read bitmap is emptied, so the row can serve the frame that is `BMAP_DEPTH` frames later.
- R7: For a banked arrival, `res_addr` = floor(dep_slot/SLOTS_PER_FRAME) mod `BMAP_DEPTH`.
- R8: No two banked packets share a bank within one arrival frame, and none shares a bank with a packet whose read frame equals its own arrival frame or its own read frame.
- R9: Every result appears exactly one clock after its `arr_valid`. `res_valid` is 0 in a cycle that follows no arrival.
- R10: When packets arrive at most once per slot, have distinct departure slots and depart fewer than `BMAP_DEPTH` frames ahead, a banked arrival always finds at least one candidate bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | A packet arrives in this cycle |
| now_slot | input | SLOT_W | Current time slot; advances by at most one per cycle, never backwards |
| dep_slot | input | SLOT_W | Departure slot of the arriving packet |
| res_valid | output | 1 | Result for the previous cycle's arrival |
| res_bypass | output | 1 | Packet goes to the side buffer, not a bank |
| res_bank | output | $clog2(3*SLOTS_PER_FRAME-1) | Chosen bank |
| res_addr | output | $clog2(BMAP_DEPTH) | Word address within the chosen bank |

## Verification
Almost any fault in the internal state shows up at `res_bank` soon after it occurs. If a reservation bit is kept past a frame edge, the next arrival in that frame is steered one bank too high. If a bitmap row is not emptied, the error surfaces up to `BMAP_DEPTH` frames later, once the row is reused: the first arrival that depends on that row picks a different bank, and if enough stale bits pile up, no candidate is left. The bench therefore runs hundreds of frames, so every row is reused many times. It compares every choice with a model that is indexed by absolute frame number and has no circular rows.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
  function automatic logic [31:0] slot_to_frame(input logic [31:0] slot, input int spf);
    return slot / spf;
  endfunction

  function automatic logic too_close(input logic [31:0] now, input logic [31:0] dep, input int spf);
    return (dep < now) || ((dep - now) < 32'(4 * spf - 1));
  endfunction

  function automatic logic [31:0] wrap_row(input logic [31:0] frame, input int depth);
    return frame % depth;
  endfunction
endpackage

// File: rtl/frame_clock.sv
module frame_clock #(
  parameter int SLOT_W = 16,
  parameter int SPF    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] now_slot,
  output logic [31:0]       cur_frame,
  output logic [31:0]       prev_frame,
  output logic              frame_edge
);
  import bank_sel_pkg::*;
  logic [31:0] last_q;

  always_comb begin
    cur_frame  = slot_to_frame(32'(now_slot), SPF);
    prev_frame = last_q;
    frame_edge = (cur_frame != last_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= cur_frame;
  end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant_oh,
  output logic [IW-1:0] grant_idx,
  output logic          any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_oh[i] = req[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req[i];
  end

  assign any = seen[N];

  always_comb begin
    grant_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) grant_idx = IW'(i);
  end
endmodule

// File: rtl/occupancy_map.sv
module occupancy_map #(
  parameter int NB    = 8,
  parameter int DEPTH = 16,
  localparam int RW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_edge,
  input  logic [RW-1:0] old_row,
  input  logic [RW-1:0] arr_row,
  input  logic [RW-1:0] rd_row,
  input  logic          take,
  input  logic [NB-1:0] pick_oh,
  output logic [NB-1:0] cand_vec,
  output logic [NB-1:0] w_res
);
  logic [NB-1:0] rmap [DEPTH];
  logic [NB-1:0] w_q, w_eff;

  always_comb begin
    w_eff    = frame_edge ? '0 : w_q;
    cand_vec = ~(w_eff | rmap[arr_row] | rmap[rd_row]);
  end

  assign w_res = w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q <= '0;
      for (int r = 0; r < DEPTH; r++) rmap[r] <= '0;
    end else begin
      w_q <= w_eff | (take ? pick_oh : '0);
      for (int r = 0; r < DEPTH; r++) begin
        if (frame_edge && RW'(r) == old_row)
          rmap[r] <= '0;
        else if (take && RW'(r) == rd_row)
          rmap[r] <= rmap[r] | pick_oh;
      end
    end
  end
endmodule

// File: rtl/bank_conflict_sel.sv
module bank_conflict_sel #(
  parameter int SLOT_W          = 16,
  parameter int SLOTS_PER_FRAME = 3,
  parameter int BMAP_DEPTH      = 16,
  localparam int NB = 3 * SLOTS_PER_FRAME - 1,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int AW = (BMAP_DEPTH > 1) ? $clog2(BMAP_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  logic [SLOT_W-1:0] now_slot,
  input  logic [SLOT_W-1:0] dep_slot,
  output logic              res_valid,
  output logic              res_bypass,
  output logic [BW-1:0]     res_bank,
  output logic [AW-1:0]     res_addr
);
  import bank_sel_pkg::*;

  logic [31:0]   cur_frame, prev_frame, dep_frame, rd_frame;
  logic          frame_edge, bypass_now, take, any;
  logic [AW-1:0] old_row, arr_row, rd_row, addr_now;
  logic [NB-1:0] cand_vec, pick_oh, w_res;
  logic [BW-1:0] pick_idx;

  frame_clock #(.SLOT_W(SLOT_W), .SPF(SLOTS_PER_FRAME)) u_clock (
    .clk(clk), .rst_n(rst_n), .now_slot(now_slot),
    .cur_frame(cur_frame), .prev_frame(prev_frame), .frame_edge(frame_edge)
  );

  always_comb begin
    dep_frame  = slot_to_frame(32'(dep_slot), SLOTS_PER_FRAME);
    rd_frame   = dep_frame - 32'd1;
    bypass_now = too_close(32'(now_slot), 32'(dep_slot), SLOTS_PER_FRAME);
    take       = arr_valid & ~bypass_now;
    old_row    = AW'(wrap_row(prev_frame, BMAP_DEPTH));
    arr_row    = AW'(wrap_row(cur_frame, BMAP_DEPTH));
    rd_row     = AW'(wrap_row(rd_frame, BMAP_DEPTH));
    addr_now   = AW'(wrap_row(dep_frame, BMAP_DEPTH));
  end

  occupancy_map #(.NB(NB), .DEPTH(BMAP_DEPTH)) u_map (
    .clk(clk), .rst_n(rst_n), .frame_edge(frame_edge),
    .old_row(old_row), .arr_row(arr_row), .rd_row(rd_row),
    .take(take), .pick_oh(pick_oh), .cand_vec(cand_vec), .w_res(w_res)
  );

  lowest_pick #(.N(NB)) u_pick (
    .req(cand_vec), .grant_oh(pick_oh), .grant_idx(pick_idx), .any(any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_bypass <= 1'b0;
      res_bank   <= '0;
      res_addr   <= '0;
    end else begin
      res_valid  <= arr_valid;
      res_bypass <= arr_valid & bypass_now;
      res_bank   <= take ? pick_idx : '0;
      res_addr   <= take ? addr_now : '0;
    end
  end
endmodule

// File: rtl/bank_sel_chk.sv
module bank_sel_chk #(
  parameter int SLOT_W = 16,
  parameter int SPF    = 3,
  parameter int NB     = 8,
  parameter int BW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arr_valid,
  input logic [SLOT_W-1:0] now_slot,
  input logic [SLOT_W-1:0] dep_slot,
  input logic              res_valid,
  input logic              res_bypass,
  input logic [BW-1:0]     res_bank,
  input logic              take,
  input logic              frame_edge,
  input logic [NB-1:0]     cand_vec,
  input logic [NB-1:0]     pick_oh,
  input logic [NB-1:0]     w_res
);
  logic [NB-1:0] cand_d;
  always_ff @(posedge clk) cand_d <= cand_vec;

  // R10
  cand_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cand_vec != '0));

  // R3
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $onehot(pick_oh));

  // R3
  pick_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cand_d[res_bank]);

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |=> res_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_valid |=> !res_valid);

  // R2
  near_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && dep_slot >= now_slot && (dep_slot - now_slot) < SLOT_W'(4 * SPF - 1))
      |=> res_bypass);

  // R5
  wres_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_edge && !take) |=> (w_res == '0));

  // R4
  wres_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !frame_edge) |=> ($countones(w_res) == $countones($past(w_res)) + 1));
endmodule

bind bank_conflict_sel bank_sel_chk #(
  .SLOT_W(SLOT_W), .SPF(SLOTS_PER_FRAME), .NB(NB), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .now_slot(now_slot),
  .dep_slot(dep_slot), .res_valid(res_valid), .res_bypass(res_bypass),
  .res_bank(res_bank), .take(take), .frame_edge(frame_edge),
  .cand_vec(cand_vec), .pick_oh(pick_oh), .w_res(w_res)
);

// File: tb/bank_conflict_sel_tb.sv
`timescale 1ns/1ps
module bank_conflict_sel_tb;
  localparam int SW = 16, SPF = 3, DEP = 16, NB = 3 * SPF - 1;
  localparam int PHASE = 20, KMAX = 44;
  localparam int TOTAL = PHASE * (KMAX + 1);

  logic clk = 1'b0, rst_n = 1'b0, arr_valid = 1'b0;
  logic [SW-1:0] now_slot = '0, dep_slot = '0;
  logic res_valid, res_bypass;
  logic [2:0] res_bank;
  logic [3:0] res_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  int wabs [0:511];
  int rabs [0:511];
  bit pend = 0, e_byp;
  int e_bank, e_addr;

  always #2.5 clk = ~clk;

  bank_conflict_sel #(.SLOT_W(SW), .SLOTS_PER_FRAME(SPF), .BMAP_DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .now_slot(now_slot),
    .dep_slot(dep_slot), .res_valid(res_valid), .res_bypass(res_bypass),
    .res_bank(res_bank), .res_addr(res_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      chk("R9 valid", int'(res_valid), 1);
      chk("R2 bypass", int'(res_bypass), int'(e_byp));
      // R3,R4,R5,R6,R8,R10: absolute-frame model, no circular rows
      chk("R3 bank", int'(res_bank), e_bank);
      chk("R7 addr", int'(res_addr), e_addr);
    end else begin
      chk("R9 idle", int'(res_valid), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin wabs[i] = 0; rabs[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(res_valid), 0);
    chk("R1 bypass in reset", int'(res_bypass), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(res_valid), 0);
    chk("R1 bypass after reset", int'(res_bypass), 0);
    for (int s = 0; s < TOTAL; s++) begin
      int k, f, df, d, mask, dep;
      bit v;
      check_pending();
      k   = s / PHASE;
      v   = (s % 7) != 5;
      dep = s + k;
      now_slot  = SW'(s);
      dep_slot  = SW'(dep);
      arr_valid = v;
      pend = v;
      if (v) begin
        e_byp = (k < 4 * SPF - 1);
        f  = s / SPF;
        df = dep / SPF;
        d  = df - 1;
        if (e_byp) begin
          e_bank = 0; e_addr = 0;
        end else begin
          mask = wabs[f] | rabs[f] | rabs[d];
          e_bank = -1;
          for (int b = NB - 1; b >= 0; b--) if (((mask >> b) & 1) == 0) e_bank = b;
          e_addr = df % DEP;
          if (e_bank >= 0) begin
            wabs[f] |= (1 << e_bank);
            rabs[d] |= (1 << e_bank);
          end
        end
      end
      @(negedge clk);
    end
    check_pending();
    arr_valid = 1'b0;
    pend = 0;
    // R2: departure earlier than now is bypassed
    now_slot = SW'(TOTAL + 5);
    dep_slot = SW'(TOTAL);
    arr_valid = 1'b1;
    @(negedge clk);
    arr_valid = 1'b0;
    chk("R2 past departure bypass", int'(res_bypass), 1);
    chk("R2 past departure bank", int'(res_bank), 0);
    @(negedge clk);
    chk("R9 idle after", int'(res_valid), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule